// File: doc/BRIEF.md
# Hardware Flag Synchronization Unit

This unit holds a small bank of single-bit synchronization flags in processor storage, apart from memory. Hardware execution contexts use these flags to coordinate with one another. Every instruction that reaches the unit carries a two-bit flag operation and a four-bit flag number. One or more request lanes present these fields each cycle, together with the context word that issued them. A lane can leave the flags alone, clear one flag, set one flag, or wait on one flag.

A wait on a flag that already reads 1 passes straight through. A wait on a flag that reads 0 takes the whole context off the pipeline and stores it in a parking slot inside the unit. The context stays there until some other context sets that flag. Parked contexts whose flags read 1 are handed back on a release port. At most one is handed back per cycle, and only when the pipeline's re-entry point can take it.

A typical use has a context that spawns a helper clear a flag. The helper later sets that flag, and the spawning context waits on it before it consumes the helper's results.

Top module: `flag_sync_unit`

## Requirements
- R1: The unit holds NUM_FLAGS (default 16) flags. Bit i of `flag_state` is flag i, and the 4-bit index field of a lane selects a flag as a plain binary number (0 to 15).
- R2: The operation code on a lane is 00 for no operation, 01 for clear, 10 for set and 11 for wait. A clear or set accepted at a clock edge is visible on `flag_state` after that edge. A no-operation changes no flag.
- R3: If one lane sets a flag and another lane clears the same flag in the same cycle, the flag becomes 1.
- R4: A wait on a flag that reads 1 is accepted in the same cycle with `req_park` low. The context continues without being parked.
- R5: A wait on a flag that reads 0 is accepted with `req_park` high when a slot is free. The context is stored and is not released while its flag reads 0.
- R6: A parked context becomes eligible for release in the cycle after the edge that sets its flag. Its context word then appears on `rel_ctx` with `rel_valid` high.
- R7: At most one context leaves per cycle. When several are eligible, the one in the lowest-numbered slot goes first. Free slots are filled lowest-numbered first, and lower-numbered lanes are served first.
- R8: A release takes place only in a cycle in which `rel_ready` is high. While `rel_ready` is low, every parked context stays in its slot and `rel_valid` stays high.
- R9: A wait on a flag that reads 0 when no slot is left for it has `req_ready` low and is not taken. Every other request is always accepted.
- R10: Synchronous active-low reset clears all flags to 0 and empties all parking slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_LANES | Request present, one bit per lane |
| req_func | input | 2*NUM_LANES | Operation code per lane (00 nop, 01 clear, 10 set, 11 wait) |
| req_idx | input | IDX_W*NUM_LANES | Flag number per lane |
| req_ctx | input | CTX_W*NUM_LANES | Context word per lane |
| req_ready | output | NUM_LANES | Request accepted this cycle |
| req_park | output | NUM_LANES | Accepted request is being parked; the pipeline drops it |
| rel_valid | output | 1 | A parked context is ready to re-enter |
| rel_ctx | output | CTX_W | Context word being released |
| rel_ready | input | 1 | Pipeline re-entry point is empty |
| flag_state | output | NUM_FLAGS | Current flag values |

## Verification
Two functions of the unit can fall in the same cycle. The first is a flag update and a flag read on the same flag: one lane waits on a flag while the other lane sets it. The bench expects the waiter to park, because it sees the registered flag value, and to be released one cycle later. The second is two updates to one flag: a set on one lane and a clear on the other. Here the flag is judged to end up at 1. A scoreboard queue holds the predicted order of released contexts. While re-entry is held off, the bench also checks that a full set of slots pushes back a further wait and that eligible contexts stay in place.

// File: rtl/fsu_pkg.sv
// Package: shared operation codes for the flag synchronization unit.
package fsu_pkg;
    typedef enum logic [1:0] {
        FN_NOP  = 2'b00,
        FN_CLR  = 2'b01,
        FN_SET  = 2'b10,
        FN_WAIT = 2'b11
    } fsu_func_e;
endpackage

// File: rtl/fsu_flag_bank.sv
// Module: fsu_flag_bank
// Holds the flag bits. Each lane may raise a set or a clear request for
// one flag per cycle. A set wins over a clear to the same flag.
// Assumes: set_v/clr_v are only raised for accepted requests.
module fsu_flag_bank #(
    parameter int NUM_FLAGS = 16,
    parameter int NUM_LANES = 2,
    parameter int IDX_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LANES-1:0]         set_v,
    input  logic [NUM_LANES-1:0]         clr_v,
    input  logic [NUM_LANES*IDX_W-1:0]   lane_idx,
    output logic [NUM_FLAGS-1:0]         flags
);
    logic [NUM_FLAGS-1:0] set_mask;
    logic [NUM_FLAGS-1:0] clr_mask;

    // Gather set and clear masks over all lanes.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (set_v[l]) set_mask = set_mask | (NUM_FLAGS'(1) << lane_idx[l*IDX_W +: IDX_W]);
            if (clr_v[l]) clr_mask = clr_mask | (NUM_FLAGS'(1) << lane_idx[l*IDX_W +: IDX_W]);
        end
    end

    // Flag register: clear first, then set, so set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/fsu_park_slots.sv
// Module: fsu_park_slots
// Storage for parked contexts. Lanes that need a slot are served in lane
// order. Each takes the lowest free slot. A slot empties when drop is high.
// Assumes: drop only targets occupied slots.
module fsu_park_slots #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_LANES = 2,
    parameter int IDX_W     = 4,
    parameter int CTX_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LANES-1:0]         need,
    input  logic [NUM_LANES*IDX_W-1:0]   lane_idx,
    input  logic [NUM_LANES*CTX_W-1:0]   lane_ctx,
    output logic [NUM_LANES-1:0]         granted,
    input  logic [NUM_SLOTS-1:0]         drop,
    output logic [NUM_SLOTS-1:0]         occ,
    output logic [NUM_SLOTS*IDX_W-1:0]   slot_idx,
    output logic [NUM_SLOTS*CTX_W-1:0]   slot_ctx
);
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [NUM_SLOTS-1:0] load_v;
    logic [LANE_W-1:0]    load_lane [NUM_SLOTS];

    // Allocation: walk lanes in order, each takes the lowest untaken free slot.
    always_comb begin
        logic [NUM_SLOTS-1:0] taken;
        taken   = occ;
        granted = '0;
        load_v  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) load_lane[s] = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (need[l] && !granted[l] && !taken[s]) begin
                    granted[l]   = 1'b1;
                    taken[s]     = 1'b1;
                    load_v[s]    = 1'b1;
                    load_lane[s] = LANE_W'(l);
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // One slot: load on allocation, empty on drop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[s]                      <= 1'b0;
                slot_idx[s*IDX_W +: IDX_W]  <= '0;
                slot_ctx[s*CTX_W +: CTX_W]  <= '0;
            end else if (load_v[s]) begin
                occ[s]                      <= 1'b1;
                slot_idx[s*IDX_W +: IDX_W]  <= lane_idx[load_lane[s]*IDX_W +: IDX_W];
                slot_ctx[s*CTX_W +: CTX_W]  <= lane_ctx[load_lane[s]*CTX_W +: CTX_W];
            end else if (drop[s]) begin
                occ[s]                      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fsu_release_arb.sv
// Module: fsu_release_arb
// Fixed-priority pick of the lowest-numbered eligible slot.
// Assumes: the caller qualifies the grant with re-entry readiness.
module fsu_release_arb #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] eligible,
    output logic                 any,
    output logic [NUM_SLOTS-1:0] grant_oh,
    output logic [SLOT_W-1:0]    grant_id
);
    // Scan from slot 0 upward and keep the first hit.
    always_comb begin
        any      = 1'b0;
        grant_oh = '0;
        grant_id = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (eligible[s] && !any) begin
                any         = 1'b1;
                grant_oh[s] = 1'b1;
                grant_id    = SLOT_W'(s);
            end
        end
    end
endmodule

// File: rtl/flag_sync_unit.sv
// Module: flag_sync_unit (top)
// Decodes each lane's flag operation. It updates the flag bank, parks
// waiters whose flag reads 0, and releases parked contexts one per cycle,
// lowest slot first, when the re-entry point is ready.
// Assumes: a waiter sees the registered flag value, so a same-cycle set is
// seen one cycle later.
module flag_sync_unit #(
    parameter int NUM_FLAGS = 16,
    parameter int NUM_LANES = 2,
    parameter int NUM_SLOTS = 4,
    parameter int CTX_W     = 32,
    localparam int IDX_W    = $clog2(NUM_FLAGS),
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LANES-1:0]         req_valid,
    input  logic [NUM_LANES*2-1:0]       req_func,
    input  logic [NUM_LANES*IDX_W-1:0]   req_idx,
    input  logic [NUM_LANES*CTX_W-1:0]   req_ctx,
    output logic [NUM_LANES-1:0]         req_ready,
    output logic [NUM_LANES-1:0]         req_park,
    output logic                         rel_valid,
    output logic [CTX_W-1:0]             rel_ctx,
    input  logic                         rel_ready,
    output logic [NUM_FLAGS-1:0]         flag_state
);
    import fsu_pkg::*;

    logic [NUM_LANES-1:0]       set_v, clr_v, need, granted;
    logic [NUM_SLOTS-1:0]       slot_occ, slot_elig, slot_grant, slot_drop;
    logic [NUM_SLOTS*IDX_W-1:0] slot_idx;
    logic [NUM_SLOTS*CTX_W-1:0] slot_ctx;
    logic [SLOT_W-1:0]          grant_id;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        fsu_func_e  func;
        logic       flag_now;
        // Lane decode: classify the request against the registered flag.
        always_comb begin
            func         = fsu_func_e'(req_func[l*2 +: 2]);
            flag_now     = flag_state[req_idx[l*IDX_W +: IDX_W]];
            set_v[l]     = req_valid[l] && (func == FN_SET);
            clr_v[l]     = req_valid[l] && (func == FN_CLR);
            need[l]      = req_valid[l] && (func == FN_WAIT) && !flag_now;
            req_ready[l] = !need[l] || granted[l];
            req_park[l]  = need[l] && granted[l];
        end
    end

    fsu_flag_bank #(
        .NUM_FLAGS (NUM_FLAGS),
        .NUM_LANES (NUM_LANES),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_v    (set_v),
        .clr_v    (clr_v),
        .lane_idx (req_idx),
        .flags    (flag_state)
    );

    fsu_park_slots #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_LANES (NUM_LANES),
        .IDX_W     (IDX_W),
        .CTX_W     (CTX_W)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .need     (need),
        .lane_idx (req_idx),
        .lane_ctx (req_ctx),
        .granted  (granted),
        .drop     (slot_drop),
        .occ      (slot_occ),
        .slot_idx (slot_idx),
        .slot_ctx (slot_ctx)
    );

    // Eligibility: occupied slot whose flag now reads 1.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++)
            slot_elig[s] = slot_occ[s] && flag_state[slot_idx[s*IDX_W +: IDX_W]];
    end

    fsu_release_arb #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_arb (
        .eligible (slot_elig),
        .any      (rel_valid),
        .grant_oh (slot_grant),
        .grant_id (grant_id)
    );

    // Release port: present the chosen slot, free it only on handshake.
    always_comb begin
        rel_ctx   = slot_ctx[grant_id*CTX_W +: CTX_W];
        slot_drop = rel_ready ? slot_grant : '0;
    end
endmodule

// File: rtl/fsu_checker.sv
// Module: fsu_checker
// Temporal properties of flag_sync_unit, attached through bind.
module fsu_checker #(
    parameter int NUM_FLAGS = 16,
    parameter int NUM_LANES = 2,
    parameter int NUM_SLOTS = 4,
    parameter int IDX_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_LANES-1:0]       req_valid,
    input logic [NUM_LANES*2-1:0]     req_func,
    input logic [NUM_LANES*IDX_W-1:0] req_idx,
    input logic [NUM_LANES-1:0]       req_ready,
    input logic [NUM_LANES-1:0]       req_park,
    input logic                       rel_valid,
    input logic                       rel_ready,
    input logic [NUM_FLAGS-1:0]       flag_state,
    input logic [NUM_SLOTS-1:0]       occ,
    input logic [NUM_SLOTS-1:0]       drop
);
    logic             w0, s0;
    logic [IDX_W-1:0] i0;
    assign i0 = req_idx[IDX_W-1:0];
    assign w0 = req_valid[0] && (req_func[1:0] == 2'b11);
    assign s0 = req_valid[0] && (req_func[1:0] == 2'b10);

    p_reset_empty_r10: assert property (@(posedge clk)
        !rst_n |=> (flag_state == '0) && !rel_valid);

    p_set_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s0 |=> flag_state[$past(i0)]);

    p_hit_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && flag_state[i0]) |-> (req_ready[0] && !req_park[0]));

    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && !flag_state[i0] && (&occ)) |-> !req_ready[0]);

    p_single_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drop));

    p_hold_when_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |=> ((occ & $past(occ)) == $past(occ)));

    if (NUM_LANES > 1) begin : g_pair
        logic [IDX_W-1:0] i1;
        assign i1 = req_idx[2*IDX_W-1:IDX_W];
        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[0] && req_valid[1] && (i0 == i1) &&
             (((req_func[1:0] == 2'b10) && (req_func[3:2] == 2'b01)) ||
              ((req_func[1:0] == 2'b01) && (req_func[3:2] == 2'b10))))
            |=> flag_state[$past(i0)]);
    end
endmodule

bind flag_sync_unit fsu_checker #(
    .NUM_FLAGS (NUM_FLAGS),
    .NUM_LANES (NUM_LANES),
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_fsu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_func   (req_func),
    .req_idx    (req_idx),
    .req_ready  (req_ready),
    .req_park   (req_park),
    .rel_valid  (rel_valid),
    .rel_ready  (rel_ready),
    .flag_state (flag_state),
    .occ        (slot_occ),
    .drop       (slot_drop)
);

// File: tb/tb_flag_sync_unit.sv
module tb_flag_sync_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 2;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0]   req_valid;
    logic [NL*2-1:0] req_func;
    logic [NL*4-1:0] req_idx;
    logic [NL*CW-1:0] req_ctx;
    logic [NL-1:0]   req_ready, req_park;
    logic            rel_valid, rel_ready;
    logic [CW-1:0]   rel_ctx;
    logic [15:0]     flag_state;

    int checks = 0, fails = 0;
    logic [CW-1:0] exp_q [$];
    logic [15:0]   exp_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_sync_unit #(.NUM_FLAGS(16), .NUM_LANES(NL), .NUM_SLOTS(4), .CTX_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_func(req_func), .req_idx(req_idx), .req_ctx(req_ctx),
        .req_ready(req_ready), .req_park(req_park),
        .rel_valid(rel_valid), .rel_ctx(rel_ctx), .rel_ready(rel_ready),
        .flag_state(flag_state));

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = '0; req_func = '0; req_idx = '0; req_ctx = '0;
    endtask

    task automatic lane(input int l, input logic [1:0] f, input logic [3:0] i, input logic [CW-1:0] c);
        req_valid[l]       = 1'b1;
        req_func[l*2 +: 2] = f;
        req_idx[l*4 +: 4]  = i;
        req_ctx[l*CW +: CW] = c;
    endtask

    task automatic expect_rel(input logic [CW-1:0] c);
        exp_q.push_back(c);
    endtask

    // Monitor: compare each release handshake against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && rel_valid && rel_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7 unexpected release actual=%0h expected=none", rel_ctx);
                end else begin
                    logic [CW-1:0] e;
                    e = exp_q.pop_front();
                    if (rel_ctx !== e) begin
                        fails++;
                        $display("FAIL R6/R7 release order actual=%0h expected=%0h", rel_ctx, e);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD*150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rel_ready = 1'b1;
        rst_n = 1'b0;
        repeat (3) tick();
        #1;
        chk("R10 flags after reset", flag_state, 0);
        chk("R10 no release after reset", rel_valid, 0);
        tick(); rst_n = 1'b1;
        #1 chk("R9 idle lanes ready", req_ready, 2'b11);

        // R2 set, then R4 wait on a set flag passes through.
        tick(); lane(0, 2'b10, 4'd3, 32'h0);
        tick(); idle(); exp_flags[3] = 1'b1;
        #1 chk("R2 set flag 3", flag_state, exp_flags);
        tick(); lane(0, 2'b11, 4'd3, 32'hA0);
        #1 chk("R4 wait hit not parked", {req_ready[0], req_park[0]}, 2'b10);
        tick(); idle();
        chk("R4 nothing released", rel_valid, 0);
        // R2 clear, then nop.
        lane(0, 2'b01, 4'd3, 32'h0);
        tick(); idle(); exp_flags[3] = 1'b0;
        #1 chk("R2 clear flag 3", flag_state, exp_flags);
        tick(); lane(0, 2'b00, 4'd3, 32'h0); lane(1, 2'b00, 4'd8, 32'h0);
        tick(); idle();
        #1 chk("R2 nop leaves flags", flag_state, exp_flags);

        // R1 index mapping: flag 0 and flag 15 on two lanes.
        tick(); lane(0, 2'b10, 4'd0, 32'h0); lane(1, 2'b10, 4'd15, 32'h0);
        tick(); idle(); exp_flags[0] = 1'b1; exp_flags[15] = 1'b1;
        #1 chk("R1 binary index bits 0 and 15", flag_state, exp_flags);

        // R5/R6: park A on flag 5 and B on flag 7, release B first by setting 7.
        tick(); lane(0, 2'b11, 4'd5, 32'hA);
        #1 chk("R5 wait miss parks A", {req_ready[0], req_park[0]}, 2'b11);
        tick(); lane(0, 2'b11, 4'd7, 32'hB);
        #1 chk("R5 wait miss parks B", {req_ready[0], req_park[0]}, 2'b11);
        tick(); idle();
        repeat (3) tick();
        #1 chk("R5 parked contexts held", rel_valid, 0);
        expect_rel(32'hB);
        tick(); lane(0, 2'b10, 4'd7, 32'h0); exp_flags[7] = 1'b1;
        tick(); idle();
        #1 chk("R6 B eligible after set", {rel_valid, rel_ctx}, {1'b1, 32'hB});
        tick();
        #1 chk("R5 A still held", rel_valid, 0);
        expect_rel(32'hA);
        lane(0, 2'b10, 4'd5, 32'h0); exp_flags[5] = 1'b1;
        tick(); idle();
        tick(); tick();
        chk("R6 queue drained A B", exp_q.size(), 0);

        // R3: set on lane 1 and clear on lane 0, same flag, same cycle.
        lane(0, 2'b01, 4'd2, 32'h0); lane(1, 2'b10, 4'd2, 32'h0);
        tick(); idle(); exp_flags[2] = 1'b1;
        #1 chk("R3 set wins over clear", flag_state, exp_flags);

        // Same-cycle wait and set: waiter parks, released next cycle.
        tick(); lane(0, 2'b11, 4'd4, 32'hC4); lane(1, 2'b10, 4'd4, 32'h0);
        #1 chk("R5 wait sees old flag", req_park, 2'b01);
        expect_rel(32'hC4); exp_flags[4] = 1'b1;
        tick(); idle();
        #1 chk("R6 released cycle after set", {rel_valid, rel_ctx}, {1'b1, 32'hC4});
        tick(); tick();
        chk("R6 queue drained C4", exp_q.size(), 0);

        // R7/R8/R9: fill all slots on flag 9, hold re-entry, then drain in slot order.
        rel_ready = 1'b0;
        lane(0, 2'b11, 4'd9, 32'hC); lane(1, 2'b11, 4'd9, 32'hD);
        #1 chk("R7 two lanes park together", req_park, 2'b11);
        tick(); lane(0, 2'b11, 4'd9, 32'hE); lane(1, 2'b11, 4'd9, 32'hF);
        tick(); idle(); lane(0, 2'b11, 4'd9, 32'h6);
        #1 chk("R9 full slots stall wait", {req_ready[0], req_park[0]}, 2'b00);
        tick(); idle(); lane(1, 2'b10, 4'd9, 32'h0); exp_flags[9] = 1'b1;
        #1 chk("R9 set accepted while full", req_ready[1], 1'b1);
        expect_rel(32'hC); expect_rel(32'hD); expect_rel(32'hE); expect_rel(32'hF);
        tick(); idle();
        repeat (3) tick();
        #1 chk("R8 held while not ready", {rel_valid, rel_ctx}, {1'b1, 32'hC});
        chk("R8 nothing left early", exp_q.size(), 4);
        tick(); rel_ready = 1'b1;
        repeat (6) tick();
        chk("R7 drained C D E F in order", exp_q.size(), 0);
        #1 chk("R6 no release when empty", rel_valid, 0);
        chk("R2 final flags", flag_state, exp_flags);

        // R10: reset mid-run clears flags.
        tick(); rst_n = 1'b0;
        tick(); rst_n = 1'b1;
        #1 chk("R10 reset clears flags", flag_state, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule